// File: doc/BRIEF.md
# DMA Command Sequence Decoder

This block listens to a command/data write port and recognises the short train of address/data writes that software uses to program one page DMA transfer. Each write carries a two-bit mode field and a bank number in its address. The data word (or, for some steps, part of the address) carries a step code and transfer parameters. The decoder checks that the steps arrive in order. While the train is in progress it stages the transfer direction, page count, bank, page address, buffer address, burst length and completion-interrupt request. Once the final step is accepted, it fires a one-cycle start pulse together with a complete descriptor for the downstream data mover.

A parameter selects one of two encodings. The narrow form takes four steps and carries a 32-bit buffer address as two 16-bit halves in address bits 23:8. The wide form takes three steps: the first step's data word packs burst length, interrupt request and direction, and the next two carry the low and then the high 32 bits of a 64-bit buffer address. No sequence is accepted unless the DMA enable input is high. Any out-of-order step aborts the sequence and raises a one-cycle error pulse.

Top module: `dma_seq_decoder`

## Requirements
- R1: A write whose address bits 27:26 are not 2'b10 is ignored while the decoder waits for the first step: no start, no error, and a following valid sequence still completes.
- R2: While dma_en is low, writes are ignored. Dropping dma_en in the middle of a sequence returns the decoder to waiting for the first step without raising an error.
- R3: Narrow form, step 1: data bits 31:9 equal 0x10 (0x2000), data bit 8 is 1 for a write to flash, and data bits 7:0 are the page count. Address bits 23:0 are the page and address bits 24 upward (BANK_W bits) are the bank.
- R4: Narrow form, steps 2 and 3: the data words are exactly 0x2200 and 0x2300. Address bits 23:8 give, in that order, the upper and then the lower 16 bits of the 32-bit buffer address.
- R5: Narrow form, step 4: the data word is exactly 0x2400. Address bit 16 is the completion-interrupt request and address bits 15:8 are the burst length (0x14000 gives interrupt on, burst 64).
- R6: Wide form, step 1: data bits 31:25 are zero and data bits 15:9 equal 0x10. Bit 24 is the interrupt request, bits 23:16 the burst length, bit 8 the direction and bits 7:0 the page count. Page and bank are taken from the address as in R3.
- R7: Wide form, steps 2 and 3: any in-mode write is taken as a buffer-address word, first the low and then the high 32 bits.
- R8: start is high for exactly one cycle, in the cycle after the clock edge that accepts the final step, and never otherwise.
- R9: The descriptor outputs change only together with start and hold their values until the next start, including across aborted sequences.
- R10: In the middle of a sequence, a write with a wrong step code or with mode bits other than 2'b10 raises seq_err for one cycle (the cycle after that write) and returns the decoder to waiting for step 1.
- R11: While waiting for step 1, an in-mode write whose data is not a valid step-1 code raises seq_err for one cycle and leaves the decoder waiting for step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | DMA enable; sequences are accepted only while high |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | 28 | Write address: mode 27:26, bank from 24, payload below |
| wr_data | input | 32 | Write data: step code and parameters |
| start | output | 1 | One-cycle pulse when a full sequence is accepted |
| seq_err | output | 1 | One-cycle pulse when a sequence is aborted |
| desc_write | output | 1 | Direction: 1 = memory to flash |
| desc_count | output | 8 | Number of pages |
| desc_bank | output | BANK_W | Bank number |
| desc_page | output | 24 | Page address |
| desc_buf | output | 32 or 64 | Buffer address (64 in wide form) |
| desc_burst | output | 8 | Burst length in bytes |
| desc_irq | output | 1 | Completion interrupt requested |

## Verification
Every result of this block is due exactly one clock edge after the write that causes it. Whether a write was accepted, ignored or rejected is decided at that edge, and start, seq_err and the descriptor registers all change at the same edge. The bench therefore presents each write on a falling edge, removes it at the next falling edge, and reads start, seq_err and the descriptor right then: half a cycle after the deciding rising edge and before the next one, so a pulse is seen in the only cycle it is high. A write that should be ignored is checked by the absence of both pulses and by the behaviour of the write that follows it.

// File: rtl/dmaseq_pkg.sv
// Shared constants for the DMA command sequence decoder.
// Assumes a 28-bit command address: mode in 27:26, bank from bit 24.
package dmaseq_pkg;
    localparam int          ADDR_W     = 28;
    localparam int          DATA_W     = 32;
    localparam int          STEP_W     = 2;
    localparam int          PAGE_W     = 24;
    localparam int          CNT_W      = 8;
    localparam int          BANK_LSB   = 24;
    localparam logic [1:0]  MODE_DMA   = 2'b10;
    localparam logic [6:0]  HEAD_CODE  = 7'h10;       // data 15:9 of a step-1 word
    localparam logic [31:0] CODE_HI    = 32'h0000_2200;
    localparam logic [31:0] CODE_LO    = 32'h0000_2300;
    localparam logic [31:0] CODE_TAIL  = 32'h0000_2400;
endpackage

// File: rtl/dmaseq_decode.sv
// Combinational step-code check for the current write.
// Assumes step holds the index of the step expected next (0 = first).
module dmaseq_decode
    import dmaseq_pkg::*;
#(
    parameter bit WIDE_FORM = 1'b0
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STEP_W-1:0] step,
    output logic              in_mode,
    output logic              code_ok
);
    // mode field match
    assign in_mode = (wr_addr[27:26] == MODE_DMA);

    generate
        if (WIDE_FORM) begin : g_wide
            // only the first step carries a code; later steps are raw address words
            always_comb begin
                if (step == '0)
                    code_ok = (wr_data[31:25] == 7'd0) && (wr_data[15:9] == HEAD_CODE);
                else
                    code_ok = 1'b1;
            end
        end else begin : g_narrow
            // every step carries its own code in the data word
            always_comb begin
                case (step)
                    2'd0:    code_ok = (wr_data[31:9] == {16'd0, HEAD_CODE});
                    2'd1:    code_ok = (wr_data == CODE_HI);
                    2'd2:    code_ok = (wr_data == CODE_LO);
                    default: code_ok = (wr_data == CODE_TAIL);
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/dmaseq_ctrl.sv
// Step sequencer: advances on accepted steps, aborts on bad ones,
// and produces the start and error pulses one cycle after the deciding write.
module dmaseq_ctrl
    import dmaseq_pkg::*;
#(
    parameter int NSTEPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              wr_valid,
    input  logic              in_mode,
    input  logic              code_ok,
    output logic [STEP_W-1:0] step,
    output logic              adv,
    output logic              last_acc,
    output logic              start,
    output logic              seq_err
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEPS - 1);

    logic bad;

    // accept / reject classification of the current write
    always_comb begin
        adv      = dma_en && wr_valid && in_mode && code_ok;
        last_acc = adv && (step == LAST);
        if (step == '0)
            bad = dma_en && wr_valid && in_mode && !code_ok;
        else
            bad = dma_en && wr_valid && !(in_mode && code_ok);
    end

    // step counter and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= '0;
            start   <= 1'b0;
            seq_err <= 1'b0;
        end else begin
            start   <= last_acc;
            seq_err <= bad;
            if (!dma_en || bad || last_acc)
                step <= '0;
            else if (adv)
                step <= step + 1'b1;
        end
    end
endmodule

// File: rtl/dmaseq_capture.sv
// Stages transfer fields step by step and publishes the descriptor
// on the accepted final step. Assumes adv/last_acc come from dmaseq_ctrl.
module dmaseq_capture
    import dmaseq_pkg::*;
#(
    parameter bit WIDE_FORM = 1'b0,
    parameter int BANK_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           adv,
    input  logic                           last_acc,
    input  logic [STEP_W-1:0]              step,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic                           desc_write,
    output logic [CNT_W-1:0]               desc_count,
    output logic [BANK_W-1:0]              desc_bank,
    output logic [PAGE_W-1:0]              desc_page,
    output logic [(WIDE_FORM?64:32)-1:0]   desc_buf,
    output logic [7:0]                     desc_burst,
    output logic                           desc_irq
);
    localparam int BUF_W = WIDE_FORM ? 64 : 32;

    logic              s_write, n_write;
    logic [CNT_W-1:0]  s_count, n_count;
    logic [BANK_W-1:0] s_bank,  n_bank;
    logic [PAGE_W-1:0] s_page,  n_page;
    logic [BUF_W-1:0]  s_buf,   n_buf;
    logic [7:0]        s_burst, n_burst;
    logic              s_irq,   n_irq;

    generate
        if (WIDE_FORM) begin : g_wide
            // step 0: header word; step 1: low address; step 2: high address
            always_comb begin
                {n_write, n_count, n_bank, n_page, n_buf, n_burst, n_irq} =
                    {s_write, s_count, s_bank, s_page, s_buf, s_burst, s_irq};
                case (step)
                    2'd0: begin
                        n_write = wr_data[8];
                        n_count = wr_data[7:0];
                        n_burst = wr_data[23:16];
                        n_irq   = wr_data[24];
                        n_page  = wr_addr[PAGE_W-1:0];
                        n_bank  = wr_addr[BANK_LSB +: BANK_W];
                    end
                    2'd1:    n_buf[31:0]  = wr_data;
                    default: n_buf[63:32] = wr_data;
                endcase
            end
        end else begin : g_narrow
            // step 0: header; 1: upper half; 2: lower half; 3: burst/irq
            always_comb begin
                {n_write, n_count, n_bank, n_page, n_buf, n_burst, n_irq} =
                    {s_write, s_count, s_bank, s_page, s_buf, s_burst, s_irq};
                case (step)
                    2'd0: begin
                        n_write = wr_data[8];
                        n_count = wr_data[7:0];
                        n_page  = wr_addr[PAGE_W-1:0];
                        n_bank  = wr_addr[BANK_LSB +: BANK_W];
                    end
                    2'd1: n_buf[31:16] = wr_addr[23:8];
                    2'd2: n_buf[15:0]  = wr_addr[23:8];
                    default: begin
                        n_burst = wr_addr[15:8];
                        n_irq   = wr_addr[16];
                    end
                endcase
            end
        end
    endgenerate

    // staging and descriptor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {s_write, s_count, s_bank, s_page, s_buf, s_burst, s_irq} <= '0;
            {desc_write, desc_count, desc_bank, desc_page, desc_buf, desc_burst, desc_irq} <= '0;
        end else begin
            if (adv)
                {s_write, s_count, s_bank, s_page, s_buf, s_burst, s_irq} <=
                    {n_write, n_count, n_bank, n_page, n_buf, n_burst, n_irq};
            if (last_acc)
                {desc_write, desc_count, desc_bank, desc_page, desc_buf, desc_burst, desc_irq} <=
                    {n_write, n_count, n_bank, n_page, n_buf, n_burst, n_irq};
        end
    end
endmodule

// File: rtl/dma_seq_decoder.sv
// Top: decodes a multi-write DMA programming sequence into one start
// pulse plus descriptor. WIDE_FORM picks the three-step 64-bit encoding;
// otherwise the four-step 32-bit encoding is used. BANK_W must be 1 or 2.
module dma_seq_decoder
    import dmaseq_pkg::*;
#(
    parameter bit WIDE_FORM = 1'b0,
    parameter int BANK_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dma_en,
    input  logic                         wr_valid,
    input  logic [27:0]                  wr_addr,
    input  logic [31:0]                  wr_data,
    output logic                         start,
    output logic                         seq_err,
    output logic                         desc_write,
    output logic [7:0]                   desc_count,
    output logic [BANK_W-1:0]            desc_bank,
    output logic [23:0]                  desc_page,
    output logic [(WIDE_FORM?64:32)-1:0] desc_buf,
    output logic [7:0]                   desc_burst,
    output logic                         desc_irq
);
    localparam int NSTEPS = WIDE_FORM ? 3 : 4;

    logic [STEP_W-1:0] step;
    logic              in_mode, code_ok, adv, last_acc;

    dmaseq_decode #(.WIDE_FORM(WIDE_FORM)) u_decode (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .step    (step),
        .in_mode (in_mode),
        .code_ok (code_ok)
    );

    dmaseq_ctrl #(.NSTEPS(NSTEPS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en   (dma_en),
        .wr_valid (wr_valid),
        .in_mode  (in_mode),
        .code_ok  (code_ok),
        .step     (step),
        .adv      (adv),
        .last_acc (last_acc),
        .start    (start),
        .seq_err  (seq_err)
    );

    dmaseq_capture #(.WIDE_FORM(WIDE_FORM), .BANK_W(BANK_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .last_acc   (last_acc),
        .step       (step),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .desc_write (desc_write),
        .desc_count (desc_count),
        .desc_bank  (desc_bank),
        .desc_page  (desc_page),
        .desc_buf   (desc_buf),
        .desc_burst (desc_burst),
        .desc_irq   (desc_irq)
    );
endmodule

// File: rtl/dmaseq_checker.sv
// Port-level properties of dma_seq_decoder, attached by bind.
module dmaseq_checker #(
    parameter int BUF_W  = 32,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic              wr_valid,
    input logic              start,
    input logic              seq_err,
    input logic              desc_write,
    input logic [7:0]        desc_count,
    input logic [BANK_W-1:0] desc_bank,
    input logic [23:0]       desc_page,
    input logic [BUF_W-1:0]  desc_buf,
    input logic [7:0]        desc_burst,
    input logic              desc_irq
);
    // R8: start never lasts two cycles
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R8: start follows a presented write
    p_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_valid && dma_en));

    // R2: nothing happens in the cycle after enable is low
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !(start || seq_err));

    // R10: error pulse follows a presented write and never coincides with start
    p_err_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> ($past(wr_valid && dma_en) && !start));

    // R9: descriptor holds between starts
    p_desc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> ($stable(desc_buf) && $stable(desc_page) && $stable(desc_bank) &&
                    $stable(desc_count) && $stable(desc_write) &&
                    $stable(desc_burst) && $stable(desc_irq)));
endmodule

bind dma_seq_decoder dmaseq_checker #(
    .BUF_W  (WIDE_FORM ? 64 : 32),
    .BANK_W (BANK_W)
) u_dmaseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .wr_valid   (wr_valid),
    .start      (start),
    .seq_err    (seq_err),
    .desc_write (desc_write),
    .desc_count (desc_count),
    .desc_bank  (desc_bank),
    .desc_page  (desc_page),
    .desc_buf   (desc_buf),
    .desc_burst (desc_burst),
    .desc_irq   (desc_irq)
);

// File: tb/tb_dma_seq_decoder.sv
`timescale 1ns/1ps
module tb_dma_seq_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_en = 1'b0;
    logic        v_n = 1'b0, v_w = 1'b0;
    logic [27:0] addr = '0;
    logic [31:0] data = '0;

    logic        st_n, er_n, wr_n, irq_n;
    logic [7:0]  cnt_n, bur_n;
    logic [1:0]  bank_n;
    logic [23:0] page_n;
    logic [31:0] buf_n;
    logic        st_w, er_w, wr_w, irq_w;
    logic [7:0]  cnt_w, bur_w;
    logic [1:0]  bank_w;
    logic [23:0] page_w;
    logic [63:0] buf_w;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_seq_decoder #(.WIDE_FORM(1'b0), .BANK_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .wr_valid(v_n),
        .wr_addr(addr), .wr_data(data), .start(st_n), .seq_err(er_n),
        .desc_write(wr_n), .desc_count(cnt_n), .desc_bank(bank_n),
        .desc_page(page_n), .desc_buf(buf_n), .desc_burst(bur_n), .desc_irq(irq_n));

    dma_seq_decoder #(.WIDE_FORM(1'b1), .BANK_W(2)) dut_w (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .wr_valid(v_w),
        .wr_addr(addr), .wr_data(data), .start(st_w), .seq_err(er_w),
        .desc_write(wr_w), .desc_count(cnt_w), .desc_bank(bank_w),
        .desc_page(page_w), .desc_buf(buf_w), .desc_burst(bur_w), .desc_irq(irq_w));

    // narrow-form vectors: {addr, data, expect start, expect error}
    localparam int NV = 14;
    localparam logic [61:0] VEC [NV] = '{
        {28'h9000345, 32'h0000_2101, 1'b0, 1'b0},  // R3 step 1, bank 1, write, 1 page
        {28'h9ABCD00, 32'h0000_2200, 1'b0, 1'b0},  // R4 upper half
        {28'h9123400, 32'h0000_2300, 1'b0, 1'b0},  // R4 lower half
        {28'h9014000, 32'h0000_2400, 1'b1, 1'b0},  // R5 tail -> start (R8)
        {28'h4000000, 32'h0000_2000, 1'b0, 1'b0},  // R1 wrong mode while idle
        {28'h8000010, 32'h0000_2003, 1'b0, 1'b0},  // step 1
        {28'h8000000, 32'h0000_2300, 1'b0, 1'b1},  // R10 skipped step
        {28'h8000000, 32'h0000_2200, 1'b0, 1'b1},  // R11 idle, not a step-1 code
        {28'h8000010, 32'h0000_2003, 1'b0, 1'b0},  // step 1
        {28'h4000000, 32'h0000_2200, 1'b0, 1'b1},  // R10 wrong mode mid-sequence
        {28'h8000010, 32'h0000_2003, 1'b0, 1'b0},  // R3 bank 0, read, 3 pages
        {28'h800FF00, 32'h0000_2200, 1'b0, 1'b0},  // R4
        {28'h8000100, 32'h0000_2300, 1'b0, 1'b0},  // R4
        {28'h8002000, 32'h0000_2400, 1'b1, 1'b0}   // R5 burst 32, no irq
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one write on a falling edge; returns at the next falling edge, where results are due
    task automatic wr(input bit wide, input logic [27:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a;
        data = d;
        if (wide) v_w = 1'b1; else v_n = 1'b1;
        @(negedge clk);
        v_w = 1'b0;
        v_n = 1'b0;
    endtask

    task automatic narrow_a(input string req);
        wr(1'b0, 28'h9000345, 32'h2101);
        wr(1'b0, 28'h9ABCD00, 32'h2200);
        wr(1'b0, 28'h9123400, 32'h2300);
        wr(1'b0, 28'h9014000, 32'h2400);
        chk(req, {62'd0, st_n, er_n}, 64'd2);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset start/err", {62'd0, st_n, er_n}, 64'd0);
        chk("reset desc", {wr_n, cnt_n, bank_n, page_n, buf_n}, 64'd0);
        chk("reset wide desc", buf_w, 64'd0);

        // R2: writes ignored while disabled
        wr(1'b0, 28'h9000345, 32'h2101);
        chk("R2 disabled write", {62'd0, st_n, er_n}, 64'd0);
        dma_en = 1'b1;
        // idle decoder: step-2 code must now be an error (R11), proving nothing was latched
        wr(1'b0, 28'h8000000, 32'h2200);
        chk("R2 still idle after disabled write", {62'd0, st_n, er_n}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VEC[i][61:34], VEC[i][33:2]);
            chk($sformatf("R8/R10 vector %0d", i), {62'd0, st_n, er_n}, {62'd0, VEC[i][1:0]});
            if (i == 3 || i == 9) begin
                chk("R3 header", {wr_n, cnt_n, bank_n, page_n}, {1'b1, 8'd1, 2'd1, 24'h000345});
                chk("R4 buffer", buf_n, 64'hABCD1234);
                chk("R5 tail", {irq_n, bur_n}, {1'b1, 8'h40});
            end
        end
        chk("R3 second header", {wr_n, cnt_n, bank_n, page_n}, {1'b0, 8'd3, 2'd0, 24'h000010});
        chk("R4 second buffer", buf_n, 64'h00FF0001);
        chk("R5 second tail", {irq_n, bur_n}, {1'b0, 8'h20});

        // R2: clearing enable mid-sequence resets without error
        wr(1'b0, 28'h9000345, 32'h2101);
        wr(1'b0, 28'h9ABCD00, 32'h2200);
        @(negedge clk) dma_en = 1'b0;
        @(negedge clk);
        chk("R2 enable drop no error", {62'd0, st_n, er_n}, 64'd0);
        dma_en = 1'b1;
        narrow_a("R2 fresh sequence after enable drop");
        chk("R9 desc after restart", buf_n, 64'hABCD1234);

        // R1: wrong-mode write then valid sequence
        wr(1'b0, 28'hC000000, 32'h2101);
        chk("R1 wrong mode ignored", {62'd0, st_n, er_n}, 64'd0);
        narrow_a("R1 sequence after ignored write");

        // wide form: R6, R7
        wr(1'b1, 28'hA000077, 32'h0140_2102);
        chk("R6 step 1 no pulse", {62'd0, st_w, er_w}, 64'd0);
        wr(1'b1, 28'h8000000, 32'h89AB_CDEF);
        wr(1'b1, 28'h8000000, 32'h0123_4567);
        chk("R8 wide start", {62'd0, st_w, er_w}, 64'd2);
        chk("R6 wide header", {wr_w, cnt_w, bank_w, page_w}, {1'b1, 8'd2, 2'd2, 24'h000077});
        chk("R6 wide burst/irq", {irq_w, bur_w}, {1'b1, 8'h40});
        chk("R7 wide buffer", buf_w, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        chk("R8 wide start one cycle", {63'd0, st_w}, 64'd0);

        // R11 wide: bad header
        wr(1'b1, 28'h8000000, 32'h0000_2200);
        chk("R11 wide bad header", {62'd0, st_w, er_w}, 64'd1);
        // R10 wide: wrong mode mid-sequence
        wr(1'b1, 28'h8000001, 32'h0000_2001);
        wr(1'b1, 28'h0000000, 32'h1111_1111);
        chk("R10 wide wrong mode", {62'd0, st_w, er_w}, 64'd1);
        chk("R9 wide desc held", buf_w, 64'h0123_4567_89AB_CDEF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule